// File: doc/BRIEF.md
# Infrared Receive Sample Queue

This block is the receive front end of a consumer-infrared port. It takes an already demodulated, 1-bit infrared line, samples it at a programmable rate, packs eight samples into one byte and stores the byte in a small queue. A host reaches the block through a byte-wide register window. The host finds out why the interrupt line is raised by reading an identification register. It reads the number of queued bytes from a status register, then reads the bytes as a directly addressed array and discards them all with a single write to the status register.

The sample period is `CLK_PER_BASE * divisor` clock cycles. `CLK_PER_BASE` is the number of system clocks in one period of the 115200 Hz base rate and must be at least 2. The divisor is a 16-bit value held in two byte registers. A three-state collector machine does the sampling. **OFF** is the state while the receiver is disabled. **COLLECT** shifts in one sample per sample tick. **PUSH** is the one cycle that hands the finished byte to the queue. The transitions are: OFF→COLLECT when the receiver is enabled; COLLECT→PUSH on the eighth sample tick; PUSH→COLLECT after the hand-off; COLLECT→OFF and PUSH→OFF when the receiver is disabled. A queue flush keeps the machine in COLLECT and discards the partial byte.

Register map (offsets): 0x00 master control, 0x01 interrupt enable, 0x02 receive control, 0x03 divisor low byte, 0x04 divisor high byte, 0x05 interrupt identification (read only), 0x06 queue status, 0x20 + k queued byte k. Unmapped addresses read 0x00.

Top module: `ir_rx_queue`

## Requirements
- R1: After reset, every register reads 0x00, the identification register reads 0x00 and `irq` is low.
- R2: While the receiver is enabled, the line is sampled once every `CLK_PER_BASE * divisor` cycles, with a divisor of 0 treated as 1. The first sample is taken that many cycles after the enable (or flush) takes effect. Eight samples form one byte, least significant bit first, and the byte is queued one cycle after its eighth sample.
- R3: Queued byte k reads at offset 0x20 + k, oldest first. Status register bits [5:0] give the number of queued bytes.
- R4: Master control bits [3:2] select the data threshold: code 0x04 means 7, code 0x0C means 25, and any other code means 1. These bits read back. The identification register reads 0x02 when the count is at or above the threshold and no overrun is pending, and 0x00 when neither condition is pending.
- R5: A byte that completes while 32 bytes (DEPTH) are queued is dropped. The count stays at 32, the stored bytes are unchanged, the overrun flag sets, and the identification register reads 0x04, which takes priority over 0x02.
- R6: `irq` is high exactly when interrupt-enable bit 0x80 is set and either bit 0x02 is set with data pending, or bit 0x04 is set with overrun pending.
- R7: Any write to the status register clears the count and the overrun flag.
- R8: Writing master control with bit 0x02 set empties the queue, clears overrun and discards the partial byte. The bit reads back as 0, and the threshold field is taken from the same write.
- R9: Writing master control with bit 0x01 set returns all registers to their reset values, empties the queue and stops the receiver.
- R10: Receive-control bit 0x80 enables the receiver. While it is clear, the line has no effect on the queue, and clearing it discards a partial byte. Bit 0x08 and the range field [2:0] are stored, read back, and do not change sampling.
- R11: Both divisor bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Demodulated infrared line, already synchronised |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register window offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `CLK_PER_BASE = 2` and the default `DEPTH = 32`. With those values one sample lasts 2 cycles at divisor 1 and 4 cycles at divisor 2. A whole byte therefore takes 16 or 32 cycles, so filling the queue past 32 entries to reach overrun takes only a few hundred cycles. The bench also reaches both thresholds (7 and 25), stopping a byte partway through, and a flush in the middle of a byte, all within short directed runs.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    // Register window offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_IEN   = 8'h01;
    localparam logic [7:0] OFS_RXC   = 8'h02;
    localparam logic [7:0] OFS_DIVL  = 8'h03;
    localparam logic [7:0] OFS_DIVH  = 8'h04;
    localparam logic [7:0] OFS_IID   = 8'h05;
    localparam logic [7:0] OFS_FSTAT = 8'h06;
    localparam logic [7:0] OFS_WIN   = 8'h20;

    // Identification codes
    localparam logic [7:0] IID_NONE  = 8'h00;
    localparam logic [7:0] IID_DATA  = 8'h02;
    localparam logic [7:0] IID_OVR   = 8'h04;

    typedef enum logic [1:0] {
        SMP_OFF,
        SMP_COLLECT,
        SMP_PUSH
    } smp_state_t;

    // Threshold code (control bits [3:2]) to byte level
    function automatic logic [7:0] thr_level(input logic [1:0] code);
        unique case (code)
            2'b01:   return 8'd7;
            2'b11:   return 8'd25;
            default: return 8'd1;
        endcase
    endfunction

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int CLK_PER_BASE = 1085
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        restart,
    input  logic [15:0] divisor,
    output logic        tick
);
    localparam int BW = (CLK_PER_BASE > 1) ? $clog2(CLK_PER_BASE) : 1;

    logic [BW-1:0] base_cnt;
    logic [15:0]   div_cnt;
    logic [15:0]   div_lim;
    logic          base_wrap;
    logic          div_wrap;

    assign div_lim   = (divisor == 16'd0) ? 16'd0 : divisor - 16'd1;
    assign base_wrap = (base_cnt == BW'(CLK_PER_BASE - 1));
    assign div_wrap  = (div_cnt >= div_lim);
    assign tick      = run && !restart && base_wrap && div_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_cnt <= '0;
            div_cnt  <= '0;
        end else if (!run || restart) begin
            base_cnt <= '0;
            div_cnt  <= '0;
        end else if (base_wrap) begin
            base_cnt <= '0;
            div_cnt  <= div_wrap ? 16'd0 : div_cnt + 16'd1;
        end else begin
            base_cnt <= base_cnt + BW'(1);
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/ir_sampler.sv
module ir_sampler
    import ir_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       flush,
    input  logic       tick,
    input  logic       line,
    output logic       push,
    output logic [7:0] byte_o
);
    smp_state_t state, state_nx;
    logic [7:0] shreg;
    logic [2:0] nbits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SMP_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SMP_OFF:     if (run) state_nx = SMP_COLLECT;
            SMP_COLLECT: begin
                if (!run)                                   state_nx = SMP_OFF;
                else if (!flush && tick && nbits == 3'd7)   state_nx = SMP_PUSH;
            end
            SMP_PUSH:    state_nx = run ? SMP_COLLECT : SMP_OFF;
            default:     state_nx = SMP_OFF;
        endcase
    end

    always_comb begin
        push   = (state == SMP_PUSH) && !flush;
        byte_o = shreg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            nbits <= '0;
        end else if (!run || flush) begin
            nbits <= '0;
        end else if (tick && state == SMP_COLLECT) begin
            shreg <= {line, shreg[7:1]};
            nbits <= nbits + 3'd1;
        end
    end

    // R10
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state == SMP_OFF);
    // R2
    push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

endmodule

// File: rtl/ir_sample_fifo.sv
module ir_sample_fifo #(
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [7:0]                   din,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overrun,
    output logic [7:0]                   rd_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];
    logic       full;

    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            overrun <= 1'b0;
        end else if (clear) begin
            count   <= '0;
            overrun <= 1'b0;
        end else if (push) begin
            if (full) overrun <= 1'b1;
            else      count   <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear && !full) mem[count[IW-1:0]] <= din;
    end

    // R5
    count_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R5
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> (count == CW'(DEPTH)) && overrun);
    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0) && !overrun);

endmodule

// File: rtl/ir_rx_queue.sv
module ir_rx_queue
    import ir_rx_pkg::*;
#(
    parameter int CLK_PER_BASE = 1085,
    parameter int DEPTH        = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [1:0]    thr_q;
    logic [7:0]    ien_q, rxc_q, divl_q, divh_q;
    logic          soft_rst, ctrl_clr, stat_wr, fifo_clear, smp_flush;
    logic          run, tick, push;
    logic [7:0]    smp_byte, fifo_rd, win_off, iid;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_ovr, data_pend, in_win;

    assign soft_rst   = wr_en && addr == OFS_CTRL && wdata[0];
    assign ctrl_clr   = wr_en && addr == OFS_CTRL && wdata[1];
    assign stat_wr    = wr_en && addr == OFS_FSTAT;
    assign fifo_clear = soft_rst || ctrl_clr || stat_wr;
    assign smp_flush  = soft_rst || ctrl_clr;
    assign run        = rxc_q[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0; ien_q <= '0; rxc_q <= '0; divl_q <= '0; divh_q <= '0;
        end else if (soft_rst) begin
            thr_q <= '0; ien_q <= '0; rxc_q <= '0; divl_q <= '0; divh_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_CTRL: thr_q  <= wdata[3:2];
                OFS_IEN:  ien_q  <= wdata & 8'h86;
                OFS_RXC:  rxc_q  <= wdata & 8'h8F;
                OFS_DIVL: divl_q <= wdata;
                OFS_DIVH: divh_q <= wdata;
                default:  ;
            endcase
        end
    end

    ir_tick_gen #(.CLK_PER_BASE(CLK_PER_BASE)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(smp_flush),
        .divisor({divh_q, divl_q}), .tick(tick)
    );

    ir_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .run(run), .flush(smp_flush), .tick(tick),
        .line(rx_line), .push(push), .byte_o(smp_byte)
    );

    assign win_off = addr - OFS_WIN;
    assign in_win  = (addr >= OFS_WIN) && (win_off < 8'(DEPTH));

    ir_sample_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(fifo_clear), .push(push), .din(smp_byte),
        .rd_idx(win_off[IW-1:0]), .count(fifo_cnt), .overrun(fifo_ovr), .rd_data(fifo_rd)
    );

    assign data_pend = (8'(fifo_cnt) >= thr_level(thr_q));
    assign iid       = fifo_ovr ? IID_OVR : (data_pend ? IID_DATA : IID_NONE);
    assign irq       = ien_q[7] && ((ien_q[1] && data_pend) || (ien_q[2] && fifo_ovr));

    always_comb begin
        rdata = 8'h00;
        if (in_win) begin
            rdata = fifo_rd;
        end else begin
            case (addr)
                OFS_CTRL:  rdata = {4'b0, thr_q, 2'b0};
                OFS_IEN:   rdata = ien_q;
                OFS_RXC:   rdata = rxc_q;
                OFS_DIVL:  rdata = divl_q;
                OFS_DIVH:  rdata = divh_q;
                OFS_IID:   rdata = iid;
                OFS_FSTAT: rdata = 8'(fifo_cnt);
                default:   rdata = 8'h00;
            endcase
        end
    end

    // R9
    soft_reset_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !run && fifo_cnt == '0);

endmodule

// File: tb/ir_rx_queue_tb.sv
module ir_rx_queue_tb;
    localparam int CPB = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    ir_rx_queue #(.CLK_PER_BASE(CPB), .DEPTH(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // One sample per bit, LSB first; call right after the enabling write.
    task automatic send_bits(input logic [7:0] b, input int n, input int per);
        for (int i = 0; i < n; i++) begin
            rx_line = b[i];
            repeat (per) @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic test_reset;
        rd(8'h00, v); chk("R1 ctrl", v, 8'h00);
        rd(8'h01, v); chk("R1 ien", v, 8'h00);
        rd(8'h02, v); chk("R1 rxc", v, 8'h00);
        rd(8'h05, v); chk("R1 iid", v, 8'h00);
        rd(8'h06, v); chk("R1 fstat", v, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic test_divisor_regs;
        wr(8'h04, 8'h12); rd(8'h04, v); chk("R11 divh", v, 8'h12);
        wr(8'h03, 8'hA7); rd(8'h03, v); chk("R11 divl", v, 8'hA7);
        wr(8'h04, 8'h00); wr(8'h03, 8'h01);
    endtask

    task automatic test_packing;
        wr(8'h01, 8'h82);
        wr(8'h02, 8'h89);
        send_bits(8'hA5, 8, CPB);
        send_bits(8'h3C, 8, CPB);
        wr(8'h02, 8'h09);
        rd(8'h06, v); chk("R3 count", v, 8'h02);
        rd(8'h20, v); chk("R2 byte0 lsb first", v, 8'hA5);
        rd(8'h21, v); chk("R3 byte1", v, 8'h3C);
        rd(8'h05, v); chk("R4 iid data thr1", v, 8'h02);
        chk("R6 irq data", {7'b0, irq}, 8'h01);
        rd(8'h02, v); chk("R10 rxc readback", v, 8'h09);
    endtask

    task automatic test_divisor_rate;
        wr(8'h06, 8'h00);
        wr(8'h03, 8'h02);
        wr(8'h02, 8'h80);
        send_bits(8'h5A, 8, CPB * 2);
        wr(8'h02, 8'h00);
        rd(8'h06, v); chk("R2 div2 count", v, 8'h01);
        rd(8'h20, v); chk("R2 div2 byte", v, 8'h5A);
        wr(8'h03, 8'h01);
    endtask

    task automatic test_disabled_and_partial;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); rx_line = i[1];
        end
        rd(8'h06, v); chk("R10 disabled ignores line", v, 8'h01);
        wr(8'h02, 8'h80);
        send_bits(8'hFF, 5, CPB);
        wr(8'h02, 8'h00);
        wr(8'h02, 8'h80);
        send_bits(8'hC3, 8, CPB);
        wr(8'h02, 8'h00);
        rd(8'h06, v); chk("R10 partial dropped count", v, 8'h02);
        rd(8'h21, v); chk("R10 fresh byte", v, 8'hC3);
    endtask

    task automatic test_threshold;
        wr(8'h06, 8'h00);
        wr(8'h00, 8'h04);
        rd(8'h00, v); chk("R4 ctrl thr7 readback", v, 8'h04);
        wr(8'h02, 8'h80);
        for (int k = 0; k < 6; k++) send_bits(8'(k + 16), 8, CPB);
        wr(8'h02, 8'h00);
        rd(8'h05, v); chk("R4 below 7", v, 8'h00);
        chk("R6 irq below thr", {7'b0, irq}, 8'h00);
        wr(8'h02, 8'h80);
        send_bits(8'h77, 8, CPB);
        wr(8'h02, 8'h00);
        rd(8'h05, v); chk("R4 at 7", v, 8'h02);
        chk("R6 irq at thr", {7'b0, irq}, 8'h01);
        wr(8'h00, 8'h0C);
        rd(8'h05, v); chk("R4 below 25", v, 8'h00);
        rd(8'h06, v); chk("R4 thr write keeps queue", v, 8'h07);
        wr(8'h00, 8'h08);
        rd(8'h05, v); chk("R4 other code thr1", v, 8'h02);
    endtask

    task automatic test_overrun;
        wr(8'h06, 8'h00);
        wr(8'h02, 8'h80);
        for (int k = 0; k < 33; k++) send_bits(8'(k * 7 + 1), 8, CPB);
        wr(8'h02, 8'h00);
        rd(8'h06, v); chk("R5 count 32", v, 8'h20);
        rd(8'h05, v); chk("R5 iid overrun", v, 8'h04);
        rd(8'h3F, v); chk("R5 last kept", v, 8'(31 * 7 + 1));
        rd(8'h20, v); chk("R3 first kept", v, 8'h01);
        wr(8'h01, 8'h80); chk("R6 global only", {7'b0, irq}, 8'h00);
        wr(8'h01, 8'h84); chk("R6 overrun en", {7'b0, irq}, 8'h01);
        wr(8'h01, 8'h04); chk("R6 no global", {7'b0, irq}, 8'h00);
        wr(8'h06, 8'h00);
        rd(8'h06, v); chk("R7 status write clears", v, 8'h00);
        rd(8'h05, v); chk("R7 overrun cleared", v, 8'h00);
    endtask

    task automatic test_fifo_clear;
        wr(8'h02, 8'h80);
        send_bits(8'h11, 8, CPB);
        send_bits(8'hFF, 4, CPB);
        wr(8'h00, 8'h0A);
        send_bits(8'h81, 8, CPB);
        wr(8'h02, 8'h00);
        rd(8'h06, v); chk("R8 clear then one byte", v, 8'h01);
        rd(8'h20, v); chk("R8 partial discarded", v, 8'h81);
        rd(8'h00, v); chk("R8 clear bit self-clears", v, 8'h08);
    endtask

    task automatic test_soft_reset;
        wr(8'h01, 8'h86); wr(8'h03, 8'h05); wr(8'h00, 8'h0C); wr(8'h02, 8'h80);
        wr(8'h00, 8'h01);
        rd(8'h00, v); chk("R9 ctrl", v, 8'h00);
        rd(8'h01, v); chk("R9 ien", v, 8'h00);
        rd(8'h02, v); chk("R9 rxc", v, 8'h00);
        rd(8'h03, v); chk("R9 divl", v, 8'h00);
        rd(8'h06, v); chk("R9 fstat", v, 8'h00);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); rx_line = i[0];
        end
        rd(8'h06, v); chk("R9 receiver stopped", v, 8'h00);
        chk("R9 irq", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_divisor_regs;
        test_packing;
        test_divisor_rate;
        test_disabled_and_partial;
        test_threshold;
        test_overrun;
        test_fifo_clear;
        test_soft_reset;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule